// File: doc/BRIEF.md
# Comparator-Steered Lookup Table

This block is a configurable combinational lookup table for a reconfigurable logic cell with K logic inputs and one output. A plain lookup table drives its multiplexer tree from the raw input bits. This one steers each level of the tree with the XOR of two neighbouring inputs. Level i selects on `lut_in[i] ^ lut_in[i+1]`. The tree therefore branches on whether a pair of variables is equal or different.

Each leaf of the tree is a static four-way selector. The last input, `lut_in[K-1]`, acts as the secondary variable, and each leaf picks constant 0, constant 1, that variable, or its complement. Given the XOR pattern and the last input, the whole input word follows uniquely. So each leaf covers exactly two minterms, and the four choices are enough to encode every truth table of K inputs.

Leaf codes are loaded through a serial shift chain on `config_clk` while `config_en` is high. The chain can be read back through `config_dout`. The output is held at 0 until a full chain's worth of bits has been shifted in since reset.

Top module: `bicond_lut`

## Requirements
- R1: While `rst_n` is low and right after reset, `lut_out` is 0 and `config_dout` is 0.
- R2: On each rising `config_clk` edge with `config_en` high, the chain shifts one bit. After 2^K shifts, the first bit shifted in sits at chain bit 0, so the bits load LSB-first.
- R3: With `config_en` low, the chain holds, whatever `config_din` does. The output function is unchanged.
- R4: Leaf j takes its 2-bit code from chain bits [2j+1:2j]. Code 00 gives 0, 01 gives 1, 10 gives `lut_in[K-1]`, and 11 gives its inverse.
- R5: The leaf index used is a (K-1)-bit value whose bit i is `lut_in[i] ^ lut_in[i+1]`.
- R6: Until 2^K bits have been shifted in since reset, `lut_out` is 0. Once the count is reached, it stays reached.
- R7: Every truth table of K inputs can be encoded, and the block then reproduces it for all 2^K input words.
- R8: `config_dout` always shows chain bit 0. Shifting 2^K more bits reads a loaded configuration back in its loading order.
- R9: A later full reload replaces the old function, and the output follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| config_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of chain and load count |
| config_en | input | 1 | Shift enable |
| config_din | input | 1 | Serial configuration data in |
| config_dout | output | 1 | Serial readback, chain bit 0 |
| lut_in | input | K | Logic inputs |
| lut_out | output | 1 | Function output |

## Verification
Some internal errors show up at the output and some at the readback pin. A corrupted leaf code or a mis-paired select shows up on `lut_out` as soon as the input reaches the affected pair of minterms. A wrong shift order shows up only after a complete load, or in the readback bit sequence one edge after each shift. A miscount of loaded bits shows as the output lagging or leading the 2^K-th edge.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  typedef enum logic [1:0] {
    LEAF_ZERO = 2'b00,
    LEAF_ONE  = 2'b01,
    LEAF_VAR  = 2'b10,
    LEAF_NVAR = 2'b11
  } leaf_code_e;

  function automatic logic leaf_value(leaf_code_e code, logic v);
    case (code)
      LEAF_ZERO: return 1'b0;
      LEAF_ONE:  return 1'b1;
      LEAF_VAR:  return v;
      default:   return ~v;
    endcase
  endfunction
endpackage

// File: rtl/bcl_cfg_chain.sv
module bcl_cfg_chain #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [N-1:0] bits,
  output logic         dout,
  output logic         full
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      cnt  <= '0;
    end else if (en) begin
      bits <= {din, bits[N-1:1]};
      if (cnt != CW'(N)) cnt <= cnt + 1'b1;
    end
  end

  assign dout = bits[0];
  assign full = (cnt == CW'(N));

  // R2: a shifted bit enters at the top of the chain
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> bits[N-1] == $past(din));
  // R3: the chain holds while shifting is disabled
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(bits));
  // R6: the load count never passes the chain length
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N));
  // R8: readback presents the next bit after each shift
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> dout == $past(bits[1]));
endmodule

// File: rtl/bcl_leaf_bank.sv
module bcl_leaf_bank
  import bcl_pkg::*;
#(
  parameter int M = 8
) (
  input  logic [2*M-1:0] cfg,
  input  logic           v,
  output logic [M-1:0]   leaf
);
  for (genvar j = 0; j < M; j++) begin : g_leaf
    assign leaf[j] = leaf_value(leaf_code_e'(cfg[2*j +: 2]), v);
  end
endmodule

// File: rtl/bcl_xor_tree.sv
module bcl_xor_tree #(
  parameter int K = 4
) (
  input  logic [(1<<(K-1))-1:0] leaf,
  input  logic [K-1:0]          x,
  output logic                  y
);
  localparam int M = 1 << (K - 1);
  logic [K-2:0]   sel;
  logic [2*M-1:1] node;

  for (genvar i = 0; i < K - 1; i++) begin : g_sel
    assign sel[i] = x[i] ^ x[i+1];
  end

  for (genvar j = 0; j < M; j++) begin : g_leaves
    assign node[M+j] = leaf[j];
  end

  for (genvar d = 0; d < K - 1; d++) begin : g_depth
    for (genvar n = (1 << d); n < (2 << d); n++) begin : g_node
      assign node[n] = sel[K-2-d] ? node[2*n+1] : node[2*n];
    end
  end

  assign y = node[1];
endmodule

// File: rtl/bicond_lut.sv
module bicond_lut #(
  parameter int K = 4
) (
  input  logic         config_clk,
  input  logic         rst_n,
  input  logic         config_en,
  input  logic         config_din,
  output logic         config_dout,
  input  logic [K-1:0] lut_in,
  output logic         lut_out
);
  localparam int M = 1 << (K - 1);
  localparam int N = 2 * M;

  logic [N-1:0] cfg_bits;
  logic         cfg_full;
  logic [M-1:0] leaf;
  logic         tree_y;

  bcl_cfg_chain #(.N(N)) u_chain (
    .clk(config_clk), .rst_n(rst_n), .en(config_en), .din(config_din),
    .bits(cfg_bits), .dout(config_dout), .full(cfg_full)
  );

  bcl_leaf_bank #(.M(M)) u_leaves (
    .cfg(cfg_bits), .v(lut_in[K-1]), .leaf(leaf)
  );

  bcl_xor_tree #(.K(K)) u_tree (
    .leaf(leaf), .x(lut_in), .y(tree_y)
  );

  assign lut_out = cfg_full & tree_y;

  // R3: with a static configuration and steady inputs the output is steady
  a_r3_static_out: assert property (@(posedge config_clk) disable iff (!rst_n)
    (!config_en && $past(!config_en) && $stable(lut_in)) |-> $stable(lut_out));
  // R6: once the full count is reached it is never lost
  a_r6_full_sticky: assert property (@(posedge config_clk) disable iff (!rst_n)
    cfg_full |=> cfg_full);
endmodule

// File: tb/bicond_lut_test.sv
module bicond_lut_test;
  localparam int K = 3;
  localparam int M = 1 << (K - 1);
  localparam int N = 2 * M;
  localparam int W = 1 << K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic [K-1:0] x = '0;
  logic y;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bicond_lut #(.K(K)) uut (
    .config_clk(clk), .rst_n(rst_n), .config_en(en), .config_din(din),
    .config_dout(dout), .lut_in(x), .lut_out(y)
  );

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Encode a truth table into leaf codes, following R4 and R5.
  function automatic logic [N-1:0] encode(logic [W-1:0] tt);
    logic [N-1:0] c = '0;
    for (int a = 0; a < M; a++) begin
      logic [1:0] f;
      for (int v = 0; v < 2; v++) begin
        logic [K-1:0] w;
        w[K-1] = v[0];
        for (int i = K - 2; i >= 0; i--) w[i] = a[i] ^ w[i+1];
        f[v] = tt[w];
      end
      if (f[0] == f[1])   c[2*a +: 2] = {1'b0, f[0]};
      else if (f[1])      c[2*a +: 2] = 2'b10;
      else                c[2*a +: 2] = 2'b11;
    end
    return c;
  endfunction

  task automatic shift_bits(logic [N-1:0] c, int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      en = 1'b1; din = c[i];
    end
    @(negedge clk);
    en = 1'b0; din = 1'b0;
  endtask

  task automatic check_table(string req, logic [W-1:0] tt);
    for (int w = 0; w < W; w++) begin
      x = K'(w);
      #1;
      check(req, y, tt[w]);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1 out in reset", y, 1'b0);
    check("R1 dout in reset", dout, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", y, 1'b0);
  endtask

  task automatic t_partial_load();
    logic [N-1:0] ones;
    for (int a = 0; a < M; a++) ones[2*a +: 2] = 2'b01;
    shift_bits(ones, N - 1);
    x = '1; #1;
    check("R6 partial load output", y, 1'b0);
    shift_bits(ones >> (N - 1), 1);
    check_table("R6 full load output", '1);
  endtask

  task automatic t_codes();
    // leaf 0 VAR, leaf 1 NVAR, leaf 2 ZERO, leaf 3 ONE
    logic [N-1:0] c = {2'b01, 2'b00, 2'b11, 2'b10};
    logic [W-1:0] tt;
    for (int w = 0; w < W; w++) begin
      logic [K-2:0] a;
      logic v;
      v = w[K-1];
      for (int i = 0; i < K - 1; i++) a[i] = w[i] ^ w[i+1];
      case (a)
        2'd0: tt[w] = v;
        2'd1: tt[w] = ~v;
        2'd2: tt[w] = 1'b0;
        default: tt[w] = 1'b1;
      endcase
    end
    shift_bits(c, N);
    check_table("R4 R5 R2 leaf codes", tt);
  endtask

  task automatic t_hold();
    logic [W-1:0] tt = 8'b1001_0110;
    shift_bits(encode(tt), N);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); din = ~din;
    end
    din = 1'b0;
    check_table("R3 hold while disabled", tt);
  endtask

  task automatic t_exhaustive();
    for (int t = 0; t < (1 << W); t++) begin
      shift_bits(encode(W'(t)), N);
      check_table("R7 R9 truth table", W'(t));
    end
  endtask

  task automatic t_readback();
    logic [N-1:0] c = encode(8'b1110_1000);
    shift_bits(c, N);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      #1;
      check("R8 readback bit", dout, c[i]);
      en = 1'b1; din = 1'b0;
    end
    @(negedge clk);
    en = 1'b0;
    check_table("R8 cleared after readback", '0);
  endtask

  initial begin
    t_reset();
    t_partial_load();
    t_codes();
    t_hold();
    t_readback();
    t_exhaustive();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule